// File: doc/BRIEF.md
# Two-Region Erase Range Walker

This block takes an erase request, given as a byte start address and a byte length, for a flash array made of two erase regions. The lower region holds small parameter blocks. The upper region starts right where the lower one ends and holds larger main blocks. The block first checks the range. If the range is legal, it splits the range into whole blocks and sends one block-erase command per block to a downstream erase engine, then reports how the request ended.

Each end of the range is judged against the block size of the region that contains it. The step size is whatever block size applies at the current cursor address, so the step grows from the small size to the large one when the walk enters the upper region. The downstream engine answers every command with an acknowledge pulse. That pulse carries a failure flag, and a single failure stops the walk. Every accepted request ends in a one-cycle `done` pulse with a two-bit status.

Top module: `erase_range_walker`

## Requirements
- R1: During reset and in the first cycle after it, `done`, `erase_req` and `busy` are all low.
- R2: A request is taken only when `req_valid` is high while `busy` is low. Each request that is taken produces exactly one `done` pulse. `busy` is high from the cycle after acceptance of a non-empty legal request until its `done`. A `req_valid` seen while `busy` is high is ignored.
- R3: The start address belongs to region 1 when it is at least `R0_BLOCKS << R0_BLK_LOG2`, and to region 0 otherwise. If its offset from that region's base is not a multiple of that region's block size, the request ends with status 01 (invalid) and no erase command is issued.
- R4: The end address (start + length) is placed in a region by the same rule, so an end exactly at the region-1 base belongs to region 1. If it is not aligned within that region, the request ends with status 01 and no command is issued.
- R5: The end address is computed one bit wider than the address, so it cannot wrap. If it lies beyond the array size (region-1 base + `R1_BLOCKS << R1_BLK_LOG2`), the request ends with status 01 and no command is issued.
- R6: A legal, non-empty request issues one command per block in ascending address order. Each step equals the block size of the region that holds the current address. The first command is at the start address. When all commands have succeeded, the status is 00 (success).
- R7: `erase_req` stays high with a stable `erase_addr` until `erase_ack` arrives. Each acknowledge cycle completes exactly one command.
- R8: An acknowledge with `erase_fail` high ends the walk. In the next cycle `done` rises with status 10 (I/O error), `erase_req` falls, and no further command is issued.
- R9: A zero-length request whose start passes the R3 and R5 rules ends with status 00 in the cycle after acceptance, with no command issued.
- R10: `done` is high for exactly one cycle. `status` is valid whenever `done` is high and never holds code 11. For invalid and zero-length requests, `done` rises in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request strobe |
| req_addr | input | ADDR_W | Byte start address of the range |
| req_len | input | ADDR_W | Byte length of the range |
| busy | output | 1 | Walk in progress; new requests ignored |
| erase_req | output | 1 | Block-erase command pending |
| erase_addr | output | ADDR_W | Byte address of the block to erase |
| erase_ack | input | 1 | Downstream command complete |
| erase_fail | input | 1 | Failure flag, valid with erase_ack |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 success, 01 invalid, 10 I/O error |

## Verification
The bench builds the walker with an 8-bit address, four 4-byte blocks in region 0 and three 16-byte blocks in region 1, which gives a 64-byte array. With these values the bench can sweep every start address from 0 to 71 against every length from 0 to 71. That sweep covers every misalignment against both block sizes, ends that land exactly on the region-1 base, ends one block past the array, and every walk that crosses from the small blocks into the large ones. Targeted cases add a failure injected at each command position, wide ranges that would wrap an 8-bit sum, and a second request arriving in the middle of a walk.

// File: rtl/ewalk_pkg.sv
package ewalk_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'b00,
    ST_INVAL = 2'b01,
    ST_IOERR = 2'b10
  } ewalk_status_e;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } ewalk_state_e;
endpackage

// File: rtl/ewalk_region_map.sv
module ewalk_region_map #(
  parameter int AW          = 32,
  parameter int R0_BLK_LOG2 = 14,
  parameter int R0_BLOCKS   = 8,
  parameter int R1_BLK_LOG2 = 17
) (
  input  logic [AW-1:0] addr,
  output logic [AW-1:0] base,
  output logic [AW-1:0] blk
);
  localparam logic [AW-1:0] R1_BASE = AW'(R0_BLOCKS) << R0_BLK_LOG2;
  localparam logic [AW-1:0] R0_SIZE = AW'(1) << R0_BLK_LOG2;
  localparam logic [AW-1:0] R1_SIZE = AW'(1) << R1_BLK_LOG2;

  function automatic logic [AW-1:0] base_of(input logic [AW-1:0] a);
    return (a >= R1_BASE) ? R1_BASE : '0;
  endfunction

  function automatic logic [AW-1:0] size_of(input logic [AW-1:0] a);
    return (a >= R1_BASE) ? R1_SIZE : R0_SIZE;
  endfunction

  assign base = base_of(addr);
  assign blk  = size_of(addr);
endmodule

// File: rtl/ewalk_range_check.sv
module ewalk_range_check #(
  parameter int ADDR_W      = 32,
  parameter int R0_BLK_LOG2 = 14,
  parameter int R0_BLOCKS   = 8,
  parameter int R1_BLK_LOG2 = 17,
  parameter int R1_BLOCKS   = 31
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] len,
  output logic              start_ok,
  output logic              end_ok,
  output logic              fits
);
  localparam int EW = ADDR_W + 1;
  localparam logic [EW-1:0] ARR_SIZE =
    (EW'(R0_BLOCKS) << R0_BLK_LOG2) + (EW'(R1_BLOCKS) << R1_BLK_LOG2);

  logic [EW-1:0] s_ext, e_ext, s_base, s_blk, e_base, e_blk;

  function automatic logic on_grid(input logic [EW-1:0] a,
                                   input logic [EW-1:0] b,
                                   input logic [EW-1:0] sz);
    return ((a - b) & (sz - EW'(1))) == '0;
  endfunction

  assign s_ext = {1'b0, start};
  assign e_ext = {1'b0, start} + {1'b0, len};

  ewalk_region_map #(.AW(EW), .R0_BLK_LOG2(R0_BLK_LOG2), .R0_BLOCKS(R0_BLOCKS),
                     .R1_BLK_LOG2(R1_BLK_LOG2))
    u_smap (.addr(s_ext), .base(s_base), .blk(s_blk));

  ewalk_region_map #(.AW(EW), .R0_BLK_LOG2(R0_BLK_LOG2), .R0_BLOCKS(R0_BLOCKS),
                     .R1_BLK_LOG2(R1_BLK_LOG2))
    u_emap (.addr(e_ext), .base(e_base), .blk(e_blk));

  assign start_ok = on_grid(s_ext, s_base, s_blk);
  assign end_ok   = on_grid(e_ext, e_base, e_blk);
  assign fits     = e_ext <= ARR_SIZE;
endmodule

// File: rtl/erase_range_walker.sv
module erase_range_walker
  import ewalk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int R0_BLK_LOG2 = 14,
  parameter int R0_BLOCKS   = 8,
  parameter int R1_BLK_LOG2 = 17,
  parameter int R1_BLOCKS   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_len,
  output logic              busy,
  output logic              erase_req,
  output logic [ADDR_W-1:0] erase_addr,
  input  logic              erase_ack,
  input  logic              erase_fail,
  output logic              done,
  output logic [1:0]        status
);
  localparam logic [ADDR_W-1:0] R1_BASE = ADDR_W'(R0_BLOCKS) << R0_BLK_LOG2;

  ewalk_state_e      state_q;
  ewalk_status_e     status_q;
  logic              done_q;
  logic [ADDR_W-1:0] cur_q, remain_q;
  logic [ADDR_W-1:0] cur_base, cur_blk, next_addr;
  logic              start_ok, end_ok, fits, range_ok;

  // Named events for the checker
  logic accept_ev, step_ev, fail_ev, last_ev, leave_r0_ev;

  ewalk_range_check #(.ADDR_W(ADDR_W), .R0_BLK_LOG2(R0_BLK_LOG2), .R0_BLOCKS(R0_BLOCKS),
                      .R1_BLK_LOG2(R1_BLK_LOG2), .R1_BLOCKS(R1_BLOCKS))
    u_range (.start(req_addr), .len(req_len), .start_ok(start_ok), .end_ok(end_ok), .fits(fits));

  ewalk_region_map #(.AW(ADDR_W), .R0_BLK_LOG2(R0_BLK_LOG2), .R0_BLOCKS(R0_BLOCKS),
                     .R1_BLK_LOG2(R1_BLK_LOG2))
    u_cur (.addr(cur_q), .base(cur_base), .blk(cur_blk));

  assign range_ok    = start_ok && end_ok && fits;
  assign next_addr   = cur_q + cur_blk;
  assign accept_ev   = req_valid && (state_q == WK_IDLE);
  assign step_ev     = (state_q == WK_RUN) && erase_ack && !erase_fail;
  assign fail_ev     = (state_q == WK_RUN) && erase_ack && erase_fail;
  assign last_ev     = step_ev && (remain_q == cur_blk);
  assign leave_r0_ev = step_ev && !last_ev && (cur_base == '0) && (next_addr == R1_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= WK_IDLE;
      status_q <= ST_OK;
      done_q   <= 1'b0;
      cur_q    <= '0;
      remain_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        WK_IDLE: begin
          if (accept_ev) begin
            if (!range_ok) begin
              done_q   <= 1'b1;
              status_q <= ST_INVAL;
            end else if (req_len == '0) begin
              done_q   <= 1'b1;
              status_q <= ST_OK;
            end else begin
              cur_q    <= req_addr;
              remain_q <= req_len;
              state_q  <= WK_RUN;
            end
          end
        end
        WK_RUN: begin
          if (fail_ev) begin
            done_q   <= 1'b1;
            status_q <= ST_IOERR;
            state_q  <= WK_IDLE;
          end else if (last_ev) begin
            done_q   <= 1'b1;
            status_q <= ST_OK;
            state_q  <= WK_IDLE;
          end else if (step_ev) begin
            cur_q    <= next_addr;
            remain_q <= remain_q - cur_blk;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign busy       = (state_q == WK_RUN);
  assign erase_req  = (state_q == WK_RUN);
  assign erase_addr = cur_q;
  assign done       = done_q;
  assign status     = status_q;
endmodule

// File: rtl/ewalk_checker.sv
module ewalk_checker #(
  parameter int ADDR_W      = 32,
  parameter int R0_BLK_LOG2 = 14,
  parameter int R0_BLOCKS   = 8,
  parameter int R1_BLK_LOG2 = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              erase_req,
  input logic [ADDR_W-1:0] erase_addr,
  input logic              erase_ack,
  input logic              erase_fail,
  input logic              done,
  input logic [1:0]        status,
  input logic              accept_ev,
  input logic              range_ok,
  input logic              leave_r0_ev
);
  localparam logic [ADDR_W-1:0] R1_BASE = ADDR_W'(R0_BLOCKS) << R0_BLK_LOG2;
  localparam logic [ADDR_W-1:0] R1_SIZE = ADDR_W'(1) << R1_BLK_LOG2;

  AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> !done && !erase_req && !busy); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R2
  AST_INVAL_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev && !range_ok |=> done && status == 2'b01 && !erase_req); // R3
  AST_R1_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && erase_ack && !erase_fail && erase_addr >= R1_BASE |=>
    done || erase_addr == $past(erase_addr) + R1_SIZE); // R6
  AST_ENTER_R1: assert property (@(posedge clk) disable iff (!rst_n)
    leave_r0_ev |=> erase_req && erase_addr == R1_BASE); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && !erase_ack |=> erase_req && $stable(erase_addr)); // R7
  AST_FAIL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    erase_req && erase_ack && erase_fail |=> done && status == 2'b10 && !erase_req); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
  AST_STATUS_CODE: assert property (@(posedge clk) disable iff (!rst_n) done |-> status != 2'b11); // R10
endmodule

bind erase_range_walker ewalk_checker #(
  .ADDR_W(ADDR_W), .R0_BLK_LOG2(R0_BLK_LOG2), .R0_BLOCKS(R0_BLOCKS), .R1_BLK_LOG2(R1_BLK_LOG2)
) u_ewalk_checker (
  .clk(clk), .rst_n(rst_n), .busy(busy), .erase_req(erase_req), .erase_addr(erase_addr),
  .erase_ack(erase_ack), .erase_fail(erase_fail), .done(done), .status(status),
  .accept_ev(accept_ev), .range_ok(range_ok), .leave_r0_ev(leave_r0_ev)
);

// File: tb/erase_range_walker_bench.sv
`timescale 1ns/1ps
module erase_range_walker_bench;
  localparam int AW = 8;
  localparam int SMALL = 4, SMALL_N = 4, BIG = 16, BIG_N = 3;
  localparam int BIG_BASE = SMALL * SMALL_N;          // 16
  localparam int ARR = BIG_BASE + BIG * BIG_N;        // 64

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0, req_len = '0;
  logic busy, erase_req, done;
  logic [AW-1:0] erase_addr;
  logic erase_ack = 1'b0, erase_fail = 1'b0;
  logic [1:0] status;

  int checks = 0, fails = 0;
  int cmd_n = 0, fail_at = -1, wcnt = 0, done_cnt = 0;
  logic [AW-1:0] cmd_log [0:63];

  always #10 clk = ~clk;

  erase_range_walker #(.ADDR_W(AW), .R0_BLK_LOG2(2), .R0_BLOCKS(SMALL_N),
                       .R1_BLK_LOG2(4), .R1_BLOCKS(BIG_N)) u_erase_range_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .busy(busy), .erase_req(erase_req), .erase_addr(erase_addr), .erase_ack(erase_ack),
    .erase_fail(erase_fail), .done(done), .status(status));

  // Downstream engine model: latency cycles from the command count
  initial begin
    forever begin
      @(negedge clk);
      if (erase_ack) begin
        erase_ack = 1'b0; erase_fail = 1'b0; wcnt = 0;
      end else if (erase_req) begin
        if (wcnt >= (cmd_n % 3)) begin
          if (cmd_n < 64) cmd_log[cmd_n] = erase_addr;
          erase_fail = (cmd_n == fail_at);
          cmd_n++;
          erase_ack = 1'b1; wcnt = 0;
        end else wcnt++;
      end
    end
  end

  always @(negedge clk) if (done) done_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int size_at(input int a); return (a < BIG_BASE) ? SMALL : BIG; endfunction
  function automatic int base_at(input int a); return (a < BIG_BASE) ? 0 : BIG_BASE; endfunction
  function automatic bit grid(input int a); return ((a - base_at(a)) % size_at(a)) == 0; endfunction

  task automatic run_req(input int s, input int l, input int fidx, input bit poke);
    int e, exp_n, exp_st, got, st, idx, dc0;
    int exp_addr [0:63];
    string tag;
    e = s + l;
    exp_n = 0;
    if (e > ARR) begin exp_st = 1; tag = "R5"; end
    else if (!grid(s)) begin exp_st = 1; tag = "R3"; end
    else if (!grid(e)) begin exp_st = 1; tag = "R4"; end
    else begin
      exp_st = 0; tag = (l == 0) ? "R9" : "R6";
      for (int a = s; a < e; a += size_at(a)) begin exp_addr[exp_n] = a; exp_n++; end
    end
    if (exp_st == 0 && fidx >= 0 && fidx < exp_n) begin exp_st = 2; exp_n = fidx + 1; tag = "R8"; end
    cmd_n = 0; fail_at = fidx; dc0 = done_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = AW'(s); req_len = AW'(l);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_st != 1 && l != 0) check(busy == 1'b1, "R2 busy", int'(busy), 1);
    if (exp_st == 1 || l == 0) check(done == 1'b1, "R10 early done", int'(done), 1);
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_addr = 8'd3; req_len = 8'd1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    got = 0; st = 3;
    for (int c = 0; c < 600 && got == 0; c++) begin
      if (done) begin got = 1; st = int'(status); end
      else @(negedge clk);
    end
    check(got == 1 && st == exp_st, {tag, " status"}, st, exp_st);
    check(cmd_n == exp_n, "R7 command count", cmd_n, exp_n);
    idx = -1;
    for (int k = 0; k < exp_n && k < cmd_n; k++)
      if (idx < 0 && int'(cmd_log[k]) != exp_addr[k]) idx = k;
    if (idx >= 0) check(1'b0, {tag, " address"}, int'(cmd_log[idx]), exp_addr[idx]);
    @(negedge clk);
    check(done == 1'b0, "R10 single pulse", int'(done), 0);
    check(done_cnt - dc0 == 1, "R2 one done", done_cnt - dc0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!done && !erase_req && !busy, "R1 reset", int'(done | erase_req | busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !erase_req && !busy, "R1 after reset", int'(done | erase_req | busy), 0);
    for (int s = 0; s < 72; s++)
      for (int l = 0; l < 72; l++) run_req(s, l, -1, 1'b0);
    for (int f = 0; f < 7; f++) run_req(0, 64, f, 1'b0);      // R8 at each position
    run_req(8, 40, 2, 1'b0);                                  // R8 across boundary
    run_req(200, 100, -1, 1'b0);                              // R5 no wrap
    run_req(48, 255, -1, 1'b0);                               // R5
    run_req(64, 0, -1, 1'b0);                                 // R9 at array end
    run_req(0, 64, -1, 1'b1);                                 // R2 ignore while busy
    run_req(12, 20, -1, 1'b1);                                // R2 ignore, R6 crossing
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule